// File: doc/BRIEF.md
# Chip-Selected Static RAM with Tristate Data Bus

This block is a 128-byte word memory that sits on a processor's shared, bidirectional 8-bit data bus. A 7-bit address picks one byte. Two select inputs gate every access. One of them is active high and the other is active low, so an external address decoder can enable the part with either sense of a decoded line. Separate read and write strobes choose the operation.

A selected write captures the byte on the bus into the addressed location at the rising clock edge. A selected read places the addressed byte on the bus through three-state drivers, combinationally, for as long as the read and select conditions hold. In every other case the block releases the bus to high impedance, so other agents can drive it. If both strobes are raised together while selected, the write wins. The drivers then stay off so the bus master's byte is not contended. The array has no reset, and its contents are undefined until they are written.

Top module: `sram_cs_bus`

## Requirements
- R1: The array holds 128 independent 8-bit locations selected by `addr[6:0]`. A value written to one location is read back unchanged after every other location has been written.
- R2: The block is selected only when `csHi` is 1 and `csLoN` is 0. Any other combination of the two selects blocks both reading and writing.
- R3: While the block is not selected, the data bus is high impedance, whatever the strobes are.
- R4: A write strobe given while the block is not selected leaves every memory location unchanged.
- R5: While the block is selected with neither strobe raised, the bus is high impedance and no location changes.
- R6: While the block is selected with `wrReq`=1 and `rdReq`=0, the byte on the bus is stored at `addr` on the rising clock edge.
- R7: While the block is selected with `rdReq`=1 and `wrReq`=0, the byte at `addr` is driven onto the bus in the same cycle, with no clock edge needed. A change of address during the read changes the driven byte at once.
- R8: While the block is selected with both strobes raised, the write is performed and the bus stays high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Writes are captured on its rising edge |
| csHi | input | 1 | Active-high chip select |
| csLoN | input | 1 | Active-low chip select |
| rdReq | input | 1 | Read strobe, active high |
| wrReq | input | 1 | Write strobe, active high |
| addr | input | 7 | Byte address |
| dataBus | inout | 8 | Shared bidirectional data bus |

## Verification
Read data is due in the same cycle as the read strobe, so the bench checks it one nanosecond after it drives the inputs at the falling edge, well before the next rising edge. A write takes effect at the first rising edge after its inputs are set. The bench therefore holds a write across exactly one rising edge, then releases the bus, and checks the stored byte through a later read. High impedance is detected through a weak pull that the bench swaps between two complementary bytes a nanosecond apart. The bus counts as floating only when it follows both values.

// File: rtl/sram_cs_pkg.sv
package sram_cs_pkg;
  // Strobes from the select/operation decoder to the storage datapath
  typedef struct packed {
    logic wrEn;   // store the bus byte at the current address
    logic rdOe;   // enable the three-state drivers with array data
  } memStrobes_t;
endpackage

// File: rtl/sram_cs_ctrl.sv
module sram_cs_ctrl
  import sram_cs_pkg::*;
(
  input  logic        csHi,
  input  logic        csLoN,
  input  logic        rdReq,
  input  logic        wrReq,
  output memStrobes_t strobes
);
  logic chipSel;

  assign chipSel = csHi & ~csLoN;

  always_comb begin
    strobes      = '0;
    if (chipSel) begin
      // write has priority; drivers stay off during any write
      strobes.wrEn = wrReq;
      strobes.rdOe = rdReq & ~wrReq;
    end
  end

  // R2 / R3: no strobe may leave the decoder unless both selects agree
  always_comb begin
    if (!$isunknown({csHi, csLoN, strobes}) && (!csHi || csLoN))
      p_unsel_quiet_r2: assert (strobes == '0)
        else $error("strobe raised while unselected");
  end
endmodule

// File: rtl/sram_cs_dpath.sv
module sram_cs_dpath
  import sram_cs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  memStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) memArr[addr] <= wrData;
  end

  assign rdData = memArr[addr];

  // checker state: the most recent write, compared on the following edge
  logic              chkValid = 1'b0;
  logic [ADDR_W-1:0] chkAddr  = '0;
  logic [DATA_W-1:0] chkData  = '0;

  always_ff @(posedge clk) begin
    if (chkValid)
      p_store_visible_r6: assert (memArr[chkAddr] == chkData)
        else $error("written byte not held in array");
    if (strobes.wrEn) begin
      chkValid <= 1'b1;
      chkAddr  <= addr;
      chkData  <= wrData;
    end
  end
endmodule

// File: rtl/sram_cs_bus.sv
module sram_cs_bus
  import sram_cs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              csHi,
  input  logic              csLoN,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dataBus
);
  memStrobes_t       strobes;
  logic [DATA_W-1:0] rdData;

  sram_cs_ctrl u_ctrl (
    .csHi    (csHi),
    .csLoN   (csLoN),
    .rdReq   (rdReq),
    .wrReq   (wrReq),
    .strobes (strobes)
  );

  sram_cs_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk     (clk),
    .strobes (strobes),
    .addr    (addr),
    .wrData  (dataBus),
    .rdData  (rdData)
  );

  assign dataBus = strobes.rdOe ? rdData : {DATA_W{1'bz}};

  // R8: with both strobes raised while selected, drivers must be off
  always_comb begin
    if (!$isunknown({csHi, csLoN, rdReq, wrReq, strobes}) &&
        csHi && !csLoN && wrReq)
      p_write_wins_r8: assert (!strobes.rdOe && strobes.wrEn)
        else $error("drivers on during a write");
  end

  // R7: a read of the last written address returns that byte on the bus
  logic              seenWr = 1'b0;
  logic [ADDR_W-1:0] lastWrAddr = '0;
  logic [DATA_W-1:0] lastWrData = '0;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      seenWr     <= 1'b1;
      lastWrAddr <= addr;
      lastWrData <= dataBus;
    end
  end

  always_comb begin
    if (seenWr && !$isunknown({strobes, addr}) && strobes.rdOe &&
        addr == lastWrAddr)
      p_read_back_r7: assert (dataBus == lastWrData)
        else $error("bus byte differs from last write");
  end
endmodule

// File: tb/sram_cs_bus_tb_top.sv
module sram_cs_bus_tb_top;
  logic       clk = 1'b0;
  logic       csHi = 1'b0, csLoN = 1'b1, rdReq = 1'b0, wrReq = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] tbDrive = '0;
  logic       tbOe = 1'b0;
  logic [7:0] pullVal = 8'hA5;
  wire  [7:0] dataBus;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  assign dataBus = tbOe ? tbDrive : 8'bz;
  assign (weak0, weak1) dataBus = pullVal;

  sram_cs_bus dut_i (
    .clk(clk), .csHi(csHi), .csLoN(csLoN), .rdReq(rdReq), .wrReq(wrReq),
    .addr(addr), .dataBus(dataBus)
  );

  // vector: {isRead, addr[6:0], data[7:0]}; reads expect data
  localparam logic [15:0] VEC [12] = '{
    {1'b0, 7'd0,   8'h11}, {1'b0, 7'd127, 8'hFE}, {1'b0, 7'd1,  8'h00},
    {1'b0, 7'd64,  8'hFF}, {1'b1, 7'd0,   8'h11}, {1'b1, 7'd127, 8'hFE},
    {1'b1, 7'd1,   8'h00}, {1'b1, 7'd64,  8'hFF}, {1'b0, 7'd42, 8'h3C},
    {1'b1, 7'd42,  8'h3C}, {1'b0, 7'd42,  8'hC3}, {1'b1, 7'd42, 8'hC3}
  };

  task automatic check(input string req, input logic [7:0] got,
                       input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // floating = bus follows the weak pull for two complementary values
  task automatic checkFloat(input string req);
    logic a, b;
    pullVal = 8'hA5; #1; a = (dataBus == 8'hA5);
    pullVal = 8'h5A; #1; b = (dataBus == 8'h5A);
    pullVal = 8'hA5;
    check(req, {7'd0, a & b}, 8'd1);
  endtask

  task automatic idle();
    csHi = 1'b0; csLoN = 1'b1; rdReq = 1'b0; wrReq = 1'b0; tbOe = 1'b0;
  endtask

  task automatic doWrite(input logic h, input logic n, input logic rd,
                         input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    csHi = h; csLoN = n; rdReq = rd; wrReq = 1'b1; addr = a;
    tbDrive = d; tbOe = 1'b1;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic doRead(input string req, input logic [6:0] a,
                        input logic [7:0] exp);
    @(negedge clk);
    csHi = 1'b1; csLoN = 1'b0; rdReq = 1'b1; wrReq = 1'b0; addr = a;
    #1;
    check(req, dataBus, exp);
    idle();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    // initial state: deselected, bus floats (R3)
    @(negedge clk); checkFloat("R3 initial");

    // vector table (R6, R7)
    foreach (VEC[i]) begin
      if (VEC[i][15]) doRead("R7 table read", VEC[i][14:8], VEC[i][7:0]);
      else doWrite(1'b1, 1'b0, 1'b0, VEC[i][14:8], VEC[i][7:0]);
    end

    // R7: address change during a read updates the bus at once
    @(negedge clk);
    csHi = 1'b1; csLoN = 1'b0; rdReq = 1'b1; addr = 7'd0; #1;
    check("R7 comb read a", dataBus, 8'h11);
    addr = 7'd127; #1;
    check("R7 comb read b", dataBus, 8'hFE);
    idle();

    // R2/R3: each unselected combination floats with read raised
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      csHi = (k == 2); csLoN = (k != 0); rdReq = 1'b1; addr = 7'd0;
      checkFloat("R3 unselected read");
      idle();
    end

    // R4/R2: unselected writes must not change location 0
    doWrite(1'b0, 1'b0, 1'b0, 7'd0, 8'h99);
    doWrite(1'b1, 1'b1, 1'b0, 7'd0, 8'h98);
    doWrite(1'b0, 1'b1, 1'b0, 7'd0, 8'h97);
    doRead("R4 unselected write ignored", 7'd0, 8'h11);

    // R5: selected, no strobe: bus floats, no change
    @(negedge clk);
    csHi = 1'b1; csLoN = 1'b0; addr = 7'd1; tbDrive = 8'h77;
    @(posedge clk); #1;
    checkFloat("R5 idle float");
    idle();
    doRead("R5 idle no change", 7'd1, 8'h00);

    // R8: both strobes: write wins, bus not driven by the block
    @(negedge clk);
    csHi = 1'b1; csLoN = 1'b0; rdReq = 1'b1; wrReq = 1'b1; addr = 7'd64;
    #1; checkFloat("R8 both strobes float");
    tbDrive = 8'h5B; tbOe = 1'b1;
    @(posedge clk); #1;
    idle();
    doRead("R8 write taken", 7'd64, 8'h5B);

    // R1: fill all locations, then read all back
    for (int a = 0; a < 128; a++)
      doWrite(1'b1, 1'b0, 1'b0, 7'(a), 8'(a * 37 + 5));
    for (int a = 0; a < 128; a++)
      doRead("R1 full array", 7'(a), 8'(a * 37 + 5));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule